// File: doc/BRIEF.md
# Multi-Source 8-Bit Timer Channel

This block is one 8-bit timer/counter channel driven by a processor. A single shared register port has two roles. A write always sets the compare value. A read returns either the live count or the last captured count, depending on the mode. The count advances on one of three internal tick enables or on rising edges of an external pin. Before it is counted, the pin passes through a two-flop synchroniser and an optional divide-by-two. The whole design runs on one system clock.

The channel counts up or down. It raises a one-cycle match pulse when the count hits its target. In counter mode, a register write also clears the count (upcount) or reloads it from the new compare value (downcount). When the channel runs from the external pin, that side effect is held pending and is carried out on the first counted edge after the channel is running. The source select and the divider enable are guarded: the source select can change only while the channel is stopped, and the divider enable can change only while the channel is stopped or running from an internal source.

Top module: `tmr8_channel`

## Requirements
- R1: After reset, the count, compare value and captured value are 0, `rd_data` reads 0 and `match` is low.
- R2: Every register write stores `wr_data` as the compare value, whatever the mode.
- R3: With `count_down` low, each counted tick adds one to the count, and the count wraps from 255 to 0.
- R4: With `count_down` high, each counted tick subtracts one from the count, and a tick at 0 reloads the compare value.
- R5: `match` is high for the single cycle after a tick whose new count equals the compare value (upcount) or equals 0 (downcount).
- R6: In counter mode (`mode` = 00), a write with an internal source clears the count to 0 (upcount) or loads `wr_data` into the count (downcount), visible in the next cycle.
- R7: In capture (01), PWM (10) and captured PWM (11) modes, a write leaves the count unchanged.
- R8: Changing `mode` or `count_down` never clears or reloads the count.
- R9: With the external source selected, a counter-mode write leaves the count unchanged and marks a clear or load as pending. The first counted external event carries out the pending action instead of stepping the count.
- R10: Source select codes: 00 is the external pin, 01 is `tick_a`, 10 is `tick_b`, 11 is `tick_c`. Only the selected source advances the count. An external event is a synchronised rising edge of `ext_pin`.
- R11: When divide-by-two is active on the external path, the count advances on every second rising edge after the channel starts running.
- R12: While `run` is low, ticks and pin edges do not change the count.
- R13: `clk_sel` is taken in only while `run` is low. `ext_div_en` is taken in only while `run` is low or an internal source is active. A change made outside these conditions is ignored.
- R14: In capture and captured PWM modes, a `cap_evt` pulse stores the count. While `mode[0]` is set, `rd_data` returns that stored value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| run | input | 1 | Channel running when high |
| clk_sel | input | 2 | Source select request |
| ext_div_en | input | 1 | Divide-by-two request for the external path |
| mode | input | 2 | 00 counter, 01 capture, 10 PWM, 11 captured PWM |
| count_down | input | 1 | Count direction, high = down |
| tick_a | input | 1 | Internal tick enable, source 01 |
| tick_b | input | 1 | Internal tick enable, source 10 |
| tick_c | input | 1 | Internal tick enable, source 11 |
| ext_pin | input | 1 | Asynchronous external count input |
| cap_evt | input | 1 | Capture strobe |
| wr_en | input | 1 | Register write strobe |
| wr_data | input | 8 | Register write data (compare value) |
| rd_data | output | 8 | Live count or captured count |
| match | output | 1 | One-cycle compare match pulse |

## Verification
The hardest case to reach is a deferred write combined with the divider. A counter-mode write is issued while the channel runs from the pin with divide-by-two active. The bench then checks that nothing changes on the first pin edge, and that the reload lands on the second edge rather than a decrement. To get there, the bench first configures the source and divider while stopped. It then tries to change both while running and shows at the ports that the attempt is ignored. Only after that does it issue the write and drive pin pulses long enough to pass the synchroniser.

// File: rtl/tmr8_channel.sv
module tmr8_channel #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         run,
  input  logic [1:0]   clk_sel,
  input  logic         ext_div_en,
  input  logic [1:0]   mode,
  input  logic         count_down,
  input  logic         tick_a,
  input  logic         tick_b,
  input  logic         tick_c,
  input  logic         ext_pin,
  input  logic         cap_evt,
  input  logic         wr_en,
  input  logic [W-1:0] wr_data,
  output logic [W-1:0] rd_data,
  output logic         match
);
  localparam logic [1:0] SRC_PIN  = 2'b00;
  localparam logic [1:0] MODE_CNT = 2'b00;

  logic [W-1:0] cnt_q, cmp_q, cap_q, cnt_nxt;
  logic [1:0]   sel_q;
  logic [2:0]   pin_sy;
  logic         div_q, div_ph, pend_q, match_q;
  logic         sel_ext, ext_rise, ext_evt, int_tick, step, ctr_wr, hit;

  assign sel_ext  = (sel_q == SRC_PIN);
  assign ext_rise = pin_sy[1] & ~pin_sy[2];
  assign ext_evt  = ext_rise & (~div_q | div_ph);
  assign int_tick = (sel_q == 2'b01) ? tick_a : (sel_q == 2'b10) ? tick_b : tick_c;
  assign step     = run & (sel_ext ? ext_evt : int_tick);
  assign ctr_wr   = wr_en & (mode == MODE_CNT);
  assign cnt_nxt  = count_down ? ((cnt_q == '0) ? cmp_q : cnt_q - 1'b1) : cnt_q + 1'b1;
  assign hit      = count_down ? (cnt_nxt == '0) : (cnt_nxt == cmp_q);
  assign rd_data  = mode[0] ? cap_q : cnt_q;
  assign match    = match_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pin_sy  <= '0;
      sel_q   <= SRC_PIN;
      div_q   <= 1'b0;
      div_ph  <= 1'b0;
      cmp_q   <= '0;
      cnt_q   <= '0;
      cap_q   <= '0;
      pend_q  <= 1'b0;
      match_q <= 1'b0;
    end else begin
      pin_sy  <= {pin_sy[1:0], ext_pin};
      match_q <= 1'b0;
      if (!run) sel_q <= clk_sel;
      if (!run || !sel_ext) div_q <= ext_div_en;
      if (!run) div_ph <= 1'b0;
      else if (sel_ext && div_q && ext_rise) div_ph <= ~div_ph;
      if (wr_en) cmp_q <= wr_data;
      if (cap_evt && mode[0]) cap_q <= cnt_q;
      if (ctr_wr && !sel_ext) begin
        cnt_q <= count_down ? wr_data : '0;
      end else if (step) begin
        if (pend_q) begin
          cnt_q  <= count_down ? cmp_q : '0;
          pend_q <= 1'b0;
        end else begin
          cnt_q   <= cnt_nxt;
          match_q <= hit;
        end
      end
      if (ctr_wr && sel_ext) pend_q <= 1'b1;
    end
  end
endmodule

module tmr8_channel_chk #(
  parameter int W = 8
) (
  input logic         clk,
  input logic         rst_n,
  input logic         run,
  input logic         wr_en,
  input logic [W-1:0] wr_data,
  input logic [1:0]   mode,
  input logic [W-1:0] cnt_q,
  input logic [W-1:0] cmp_q,
  input logic [1:0]   sel_q,
  input logic         div_q,
  input logic         step,
  input logic         match
);
  a_r2_cmp_written: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> cmp_q == $past(wr_data));
  a_r5_match_follows_step: assert property (@(posedge clk) disable iff (!rst_n)
    match |-> $past(step));
  a_r7_passive_write: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && mode != 2'b00 && !step) |=> $stable(cnt_q));
  a_r12_frozen_when_stopped: assert property (@(posedge clk) disable iff (!rst_n)
    (!run && !wr_en) |=> $stable(cnt_q));
  a_r13_sel_locked: assert property (@(posedge clk) disable iff (!rst_n)
    run |=> $stable(sel_q));
  a_r13_div_locked: assert property (@(posedge clk) disable iff (!rst_n)
    (run && sel_q == 2'b00) |=> $stable(div_q));
endmodule

bind tmr8_channel tmr8_channel_chk #(.W(W)) u_chk (
  .clk(clk), .rst_n(rst_n), .run(run), .wr_en(wr_en), .wr_data(wr_data),
  .mode(mode), .cnt_q(cnt_q), .cmp_q(cmp_q), .sel_q(sel_q), .div_q(div_q),
  .step(step), .match(match)
);

// File: tb/tb_tmr8_channel.sv
module tb_tmr8_channel;
  localparam int CLK_PERIOD = 10;

  logic clk = 0, rst_n = 0, run = 0, ext_div_en = 0, count_down = 0;
  logic tick_a = 0, tick_b = 0, tick_c = 0, ext_pin = 0, cap_evt = 0, wr_en = 0;
  logic [1:0] clk_sel = 2'b01, mode = 2'b00;
  logic [7:0] wr_data = 0, rd_data;
  logic match;
  int n_chk = 0, n_err = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  tmr8_channel dut (
    .clk(clk), .rst_n(rst_n), .run(run), .clk_sel(clk_sel), .ext_div_en(ext_div_en),
    .mode(mode), .count_down(count_down), .tick_a(tick_a), .tick_b(tick_b),
    .tick_c(tick_c), .ext_pin(ext_pin), .cap_evt(cap_evt), .wr_en(wr_en),
    .wr_data(wr_data), .rd_data(rd_data), .match(match)
  );

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string r, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_err++;
      $display("FAIL %s: got %0d expected %0d", r, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] v);
    wr_en = 1; wr_data = v; cyc(1); wr_en = 0;
  endtask

  task automatic pulse_a(input int n); tick_a = 1; cyc(n); tick_a = 0; endtask
  task automatic pulse_b(input int n); tick_b = 1; cyc(n); tick_b = 0; endtask
  task automatic pulse_c(input int n); tick_c = 1; cyc(n); tick_c = 0; endtask

  task automatic cfg(input logic [1:0] s, input logic d);
    run = 0; clk_sel = s; ext_div_en = d; cyc(1); run = 1;
  endtask

  task automatic pin_edge(input int n);
    for (int i = 0; i < n; i++) begin
      ext_pin = 1; cyc(4); ext_pin = 0; cyc(4);
    end
  endtask

  task automatic t_reset;
    cyc(3); rst_n = 1; cyc(1);
    chk("R1 rd_data", rd_data, 0);
    chk("R1 match", match, 0);
  endtask

  task automatic t_up;
    mode = 2'b00; count_down = 0; cfg(2'b01, 0);
    wr(8'd5);     chk("R6 up clear", rd_data, 0);
    pulse_a(4);   chk("R3 count", rd_data, 4); chk("R5 no match", match, 0);
    pulse_a(1);   chk("R3 count", rd_data, 5); chk("R5 match up", match, 1);
    cyc(1);       chk("R5 single cycle", match, 0);
    pulse_a(1);   chk("R3 past compare", rd_data, 6);
  endtask

  task automatic t_down;
    count_down = 1;
    wr(8'd3);     chk("R6 down load", rd_data, 3);
    pulse_a(3);   chk("R4 count", rd_data, 0); chk("R5 match zero", match, 1);
    pulse_a(1);   chk("R4 wrap reload", rd_data, 3); chk("R5 no match", match, 0);
    wr(8'd255);   chk("R6 down load", rd_data, 255);
    count_down = 0;
    pulse_a(1);   chk("R3 wrap", rd_data, 0); chk("R5 no match at wrap", match, 0);
  endtask

  task automatic t_select;
    pulse_b(3);       chk("R10 unselected tick", rd_data, 0);
    cfg(2'b10, 0);
    pulse_b(3);       chk("R10 tick_b", rd_data, 3);
    pulse_a(2);       chk("R10 tick_a ignored", rd_data, 3);
    cfg(2'b11, 0);
    pulse_c(1);       chk("R10 tick_c", rd_data, 4);
  endtask

  task automatic t_passive;
    mode = 2'b10; cyc(1);
    wr(8'd77);
    mode = 2'b01; wr(8'd9);
    mode = 2'b00; cyc(1);
    chk("R7 write in PWM/capture", rd_data, 4);
    count_down = 1; cyc(1);
    chk("R8 direction change", rd_data, 4);
    count_down = 0;
  endtask

  task automatic t_capture;
    mode = 2'b01;
    cap_evt = 1; cyc(1); cap_evt = 0;
    chk("R14 captured", rd_data, 4);
    pulse_c(3);   chk("R14 holds capture", rd_data, 4);
    mode = 2'b00; cyc(1); chk("R8 live count", rd_data, 7);
    mode = 2'b11; cyc(1); chk("R14 captured PWM read", rd_data, 4);
    mode = 2'b00; cyc(1);
  endtask

  task automatic t_ext;
    cfg(2'b00, 0);
    wr(8'd7);       chk("R9 write pending", rd_data, 7);
    pin_edge(1);    chk("R9 pending clear", rd_data, 0);
    pin_edge(1);    chk("R10 pin edge", rd_data, 1);
    pulse_a(2);     chk("R10 tick with pin source", rd_data, 1);
    run = 0;
    pin_edge(2);    chk("R12 pin ignored", rd_data, 1);
    run = 1;
    pin_edge(1);    chk("R10 pin edge", rd_data, 2);
  endtask

  task automatic t_div;
    cfg(2'b00, 1);
    pin_edge(1);    chk("R11 first edge", rd_data, 2);
    pin_edge(1);    chk("R11 second edge", rd_data, 3);
    clk_sel = 2'b01; ext_div_en = 0; cyc(1);
    pulse_a(2);     chk("R13 sel locked", rd_data, 3);
    pin_edge(2);    chk("R13 div locked", rd_data, 4);
    count_down = 1;
    wr(8'd10);      chk("R9 load pending", rd_data, 4);
    pin_edge(1);    chk("R9 divided, no event", rd_data, 4);
    pin_edge(1);    chk("R9 pending load", rd_data, 10);
    run = 0; cyc(1);
    pulse_a(3);     chk("R12 tick ignored", rd_data, 10);
    run = 1;
    pulse_a(1);     chk("R4 after restart", rd_data, 9);
  endtask

  initial begin
    t_reset;
    t_up;
    t_down;
    t_select;
    t_passive;
    t_capture;
    t_ext;
    t_div;
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_err++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end
endmodule